// File: doc/BRIEF.md
# Command Round-Trip Clock-Domain Bridge

This block moves single read or write commands from a host-bus clock domain into a system clock domain and brings a completion back. On the bus side a one-cycle request strobe is sampled together with a packed command word. The word carries a write flag, a read flag, an address and write data. The block holds that word and signals the other domain by flipping a request toggle. The system side then issues a one-cycle write or read enable with the address.

For a read, the system side captures the read data one cycle after the enable cycle. It then flips an acknowledge toggle back to the bus domain. There the bus side raises a one-cycle acknowledge pulse and presents the returned word, which stays steady until the next completion.

Only one command is in flight at a time. A busy output covers the outstanding window, and a request strobe that arrives during that window is dropped. Each domain has its own synchronous active-high reset.

Top module: `cmd_cdc_bridge`

## Requirements
- R1: A `bus_req` pulse sampled while `bus_busy` is low is accepted, and `bus_busy` is high from the next bus cycle on.
- R2: An accepted command whose write flag (bit 55) is set produces exactly one system cycle with `sys_wr_en` high. In that cycle `sys_addr` equals command bits 53:32 and `sys_wdata` equals command bits 31:0.
- R3: An accepted command with only the read flag (bit 54) set produces exactly one system cycle with `sys_rd_en` high and `sys_addr` equal to bits 53:32. Bits 31:0 are ignored: `sys_wdata` keeps the value of the last write.
- R4: For a read, `sys_rdata` is sampled at the system clock edge that ends the cycle after the `sys_rd_en` cycle, and that value is returned on `bus_rdata`.
- R5: Each accepted command yields exactly one `bus_ack` pulse one bus cycle long. `bus_rdata` is valid in that cycle and changes in no other cycle.
- R6: A `bus_req` pulse sampled while `bus_busy` is high is ignored. It causes no system enable and no `bus_ack`.
- R7: `bus_busy` stays high until the acknowledge comes back and is low in the `bus_ack` cycle.
- R8: `sys_wr_en` and `sys_rd_en` are never high together, and neither is high in two consecutive cycles.
- R9: Reset clears `bus_busy`, `bus_ack`, `sys_wr_en` and `sys_rd_en`. `bus_rdata`, `sys_addr` and `sys_wdata` reset to zero.
- R10: Every accepted write reaches the system side exactly once, whatever the ratio of the two clock frequencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host-bus domain clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_req | input | 1 | One-cycle command strobe |
| bus_cmd | input | 56 | Packed command: write flag, read flag, address, write data (MSB first) |
| bus_busy | output | 1 | A command is outstanding |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Returned word, valid from the acknowledge on |
| sys_clk | input | 1 | System domain clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| sys_addr | output | 22 | System address |
| sys_wr_en | output | 1 | One-cycle write enable |
| sys_wdata | output | 32 | System write data |
| sys_rd_en | output | 1 | One-cycle read enable |
| sys_rdata | input | 32 | System read data |

## Verification
The checks assume that an accepted command has at most one of the two flags set. They also assume that each domain's reset is released cleanly on its own clock. The stimulus always builds commands with exactly one flag set and toggles both resets away from the active edges. It deliberately fires extra strobes only while `bus_busy` is high, since those must be dropped. The system-side responder drives the read word for a single cycle and a garbage pattern otherwise, so a misplaced read sample shows up as wrong returned data.

// File: rtl/cdc_bridge_pkg.sv
`timescale 1ns/1ps
package cdc_bridge_pkg;
  localparam int FLAG_W = 2;

  typedef enum logic [1:0] {
    SYS_IDLE   = 2'd0,
    SYS_WRITE  = 2'd1,
    SYS_READ   = 2'd2,
    SYS_RDWAIT = 2'd3
  } sys_state_e;

  function automatic int cmd_width(input int addr_w, input int data_w);
    return FLAG_W + addr_w + data_w;
  endfunction
endpackage

// File: rtl/cdc_sync_bit.sv
`timescale 1ns/1ps
module cdc_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_bus_side.sv
`timescale 1ns/1ps
module bridge_bus_side #(
  parameter int CMD_W  = 56,
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_req,
  input  logic [CMD_W-1:0]  bus_cmd,
  input  logic              ack_tgl_async,
  input  logic [DATA_W-1:0] ret_data_async,
  output logic              req_tgl,
  output logic [CMD_W-1:0]  hold_q,
  output logic              bus_busy,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata
);
  logic ack_sync;
  logic ack_seen;
  logic ack_edge;
  logic accept;

  cdc_sync_bit #(.STAGES(STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl_async), .q(ack_sync)
  );

  assign ack_edge = ack_sync ^ ack_seen;
  assign accept   = bus_req & ~bus_busy;

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      req_tgl   <= 1'b0;
      hold_q    <= '0;
      bus_busy  <= 1'b0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      ack_seen  <= 1'b0;
    end else begin
      bus_ack <= 1'b0;
      if (accept) begin
        hold_q   <= bus_cmd;
        req_tgl  <= ~req_tgl;
        bus_busy <= 1'b1;
      end else if (bus_busy && ack_edge) begin
        ack_seen  <= ack_sync;
        bus_rdata <= ret_data_async;
        bus_ack   <= 1'b1;
        bus_busy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bridge_sys_side.sv
`timescale 1ns/1ps
module bridge_sys_side
  import cdc_bridge_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32,
  parameter int STAGES = 2,
  localparam int CMD_W = FLAG_W + ADDR_W + DATA_W
) (
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic              req_tgl_async,
  input  logic [CMD_W-1:0]  hold_async,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              sys_wr_en,
  output logic [DATA_W-1:0] sys_wdata,
  output logic              sys_rd_en,
  input  logic [DATA_W-1:0] sys_rdata,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] ret_data
);
  localparam int WFLAG_BIT = CMD_W - 1;
  localparam int RFLAG_BIT = CMD_W - 2;
  localparam int ADDR_LSB  = DATA_W;

  sys_state_e  state;
  logic        req_sync;
  logic        req_seen;
  logic        req_edge;
  logic        cmd_wr;
  logic        cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  cdc_sync_bit #(.STAGES(STAGES)) u_req_sync (
    .clk(sys_clk), .rst(sys_rst), .d(req_tgl_async), .q(req_sync)
  );

  assign req_edge = req_sync ^ req_seen;
  assign cmd_wr   = hold_async[WFLAG_BIT];
  assign cmd_rd   = hold_async[RFLAG_BIT];
  assign cmd_addr = hold_async[ADDR_LSB +: ADDR_W];
  assign cmd_data = hold_async[DATA_W-1:0];

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      state     <= SYS_IDLE;
      req_seen  <= 1'b0;
      ack_tgl   <= 1'b0;
      sys_addr  <= '0;
      sys_wdata <= '0;
      sys_wr_en <= 1'b0;
      sys_rd_en <= 1'b0;
      ret_data  <= '0;
    end else begin
      case (state)
        SYS_IDLE: begin
          if (req_edge) begin
            req_seen <= req_sync;
            sys_addr <= cmd_addr;
            if (cmd_wr) begin
              sys_wdata <= cmd_data;
              sys_wr_en <= 1'b1;
              state     <= SYS_WRITE;
            end else if (cmd_rd) begin
              sys_rd_en <= 1'b1;
              state     <= SYS_READ;
            end else begin
              ack_tgl <= ~ack_tgl;
            end
          end
        end
        SYS_WRITE: begin
          sys_wr_en <= 1'b0;
          ack_tgl   <= ~ack_tgl;
          state     <= SYS_IDLE;
        end
        SYS_READ: begin
          sys_rd_en <= 1'b0;
          state     <= SYS_RDWAIT;
        end
        SYS_RDWAIT: begin
          ret_data <= sys_rdata;
          ack_tgl  <= ~ack_tgl;
          state    <= SYS_IDLE;
        end
        default: state <= SYS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_cdc_bridge.sv
`timescale 1ns/1ps
module cmd_cdc_bridge
  import cdc_bridge_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32,
  parameter int STAGES = 2,
  localparam int CMD_W = FLAG_W + ADDR_W + DATA_W
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_req,
  input  logic [CMD_W-1:0]  bus_cmd,
  output logic              bus_busy,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sys_clk,
  input  logic              sys_rst,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              sys_wr_en,
  output logic [DATA_W-1:0] sys_wdata,
  output logic              sys_rd_en,
  input  logic [DATA_W-1:0] sys_rdata
);
  logic              req_tgl;
  logic              ack_tgl;
  logic [CMD_W-1:0]  hold_q;
  logic [DATA_W-1:0] ret_data;

  bridge_bus_side #(.CMD_W(CMD_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_bus (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .ack_tgl_async(ack_tgl), .ret_data_async(ret_data),
    .req_tgl(req_tgl), .hold_q(hold_q),
    .bus_busy(bus_busy), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  bridge_sys_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_sys (
    .sys_clk(sys_clk), .sys_rst(sys_rst),
    .req_tgl_async(req_tgl), .hold_async(hold_q),
    .sys_addr(sys_addr), .sys_wr_en(sys_wr_en), .sys_wdata(sys_wdata),
    .sys_rd_en(sys_rd_en), .sys_rdata(sys_rdata),
    .ack_tgl(ack_tgl), .ret_data(ret_data)
  );
endmodule

// File: rtl/cmd_cdc_bridge_chk.sv
`timescale 1ns/1ps
module cmd_cdc_bridge_chk #(
  parameter int CMD_W  = 56,
  parameter int DATA_W = 32
) (
  input logic              bus_clk,
  input logic              bus_rst,
  input logic              bus_req,
  input logic              bus_busy,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CMD_W-1:0]  hold_q,
  input logic              sys_clk,
  input logic              sys_rst,
  input logic              sys_wr_en,
  input logic              sys_rd_en
);
  assert_busy_rise_R1: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(bus_busy) |-> $past(bus_req));

  assert_hold_stable_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_busy |=> (!bus_busy || $stable(hold_q)));

  assert_ack_pulse_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_ack |=> !bus_ack);

  assert_rdata_only_on_ack_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !$stable(bus_rdata) |-> bus_ack);

  assert_idle_at_ack_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
    bus_ack |-> !bus_busy);

  assert_ack_after_busy_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(bus_ack) |-> $past(bus_busy));

  assert_enables_exclusive_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !(sys_wr_en && sys_rd_en));

  assert_wr_single_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sys_wr_en |=> !sys_wr_en);

  assert_rd_single_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sys_rd_en |=> !sys_rd_en);
endmodule

bind cmd_cdc_bridge cmd_cdc_bridge_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_req(bus_req), .bus_busy(bus_busy),
  .bus_ack(bus_ack), .bus_rdata(bus_rdata), .hold_q(hold_q),
  .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_wr_en(sys_wr_en), .sys_rd_en(sys_rd_en)
);

// File: tb/tb_cmd_cdc_bridge.sv
`timescale 1ns/1ps
module tb_cmd_cdc_bridge;
  localparam int AW = 22;
  localparam int DW = 32;
  localparam int CW = 2 + AW + DW;

  logic bus_clk = 1'b0, sys_clk = 1'b0;
  logic bus_rst = 1'b1, sys_rst = 1'b1;
  logic bus_req = 1'b0;
  logic [CW-1:0] bus_cmd = '0;
  logic bus_busy, bus_ack, sys_wr_en, sys_rd_en;
  logic [DW-1:0] bus_rdata, sys_wdata;
  logic [DW-1:0] sys_rdata = 32'hDEAD_BEEF;
  logic [AW-1:0] sys_addr;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, ack_cnt = 0;
  bit exp_is_wr = 1'b0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic [DW-1:0] last_wdata = '0;

  always #2.5 bus_clk = ~bus_clk;
  always #3.7 sys_clk = ~sys_clk;

  cmd_cdc_bridge dut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_busy(bus_busy), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .sys_clk(sys_clk), .sys_rst(sys_rst), .sys_addr(sys_addr),
    .sys_wr_en(sys_wr_en), .sys_wdata(sys_wdata), .sys_rd_en(sys_rd_en),
    .sys_rdata(sys_rdata)
  );

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    return {a[9:0] ^ 10'h35A, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // System-side responder and monitor; read word is valid for one cycle only (R4)
  initial begin
    bit pend = 1'b0, prev_wr = 1'b0, prev_rd = 1'b0;
    logic [AW-1:0] pa = '0;
    forever begin
      @(negedge sys_clk);
      if (sys_rst) begin
        pend = 1'b0; prev_wr = 1'b0; prev_rd = 1'b0;
        sys_rdata = 32'hDEAD_BEEF;
      end else begin
        if (pend) begin sys_rdata = rd_model(pa); pend = 1'b0; end
        else sys_rdata = 32'hDEAD_BEEF;
        if (sys_wr_en) begin
          wr_cnt++;
          chk(exp_is_wr && sys_addr == exp_addr && sys_wdata == exp_data,
              "R2 write addr/data", {10'd0, sys_addr, sys_wdata}, {10'd0, exp_addr, exp_data});
          chk(!prev_wr, "R8 write enable one cycle", 64'(prev_wr), 64'd0);
        end
        if (sys_rd_en) begin
          rd_cnt++;
          chk(!exp_is_wr && sys_addr == exp_addr, "R3 read addr", 64'(sys_addr), 64'(exp_addr));
          chk(sys_wdata == last_wdata, "R3 wdata untouched by read", 64'(sys_wdata), 64'(last_wdata));
          chk(!prev_rd, "R8 read enable one cycle", 64'(prev_rd), 64'd0);
          pend = 1'b1; pa = sys_addr;
        end
        if (sys_wr_en && sys_rd_en) chk(1'b0, "R8 both enables", 64'd1, 64'd0);
        prev_wr = sys_wr_en; prev_rd = sys_rd_en;
      end
    end
  end

  // Bus-side monitor
  initial begin
    bit prev_ack = 1'b0;
    forever begin
      @(negedge bus_clk);
      if (!bus_rst && bus_ack) begin
        ack_cnt++;
        if (prev_ack) chk(1'b0, "R5 ack one cycle", 64'd1, 64'd0);
      end
      prev_ack = bus_ack;
    end
  end

  task automatic txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit inject);
    int wc0, rc0, ac0, n;
    logic [DW-1:0] junk;
    exp_is_wr = w; exp_addr = a; exp_data = d;
    wc0 = wr_cnt; rc0 = rd_cnt; ac0 = ack_cnt;
    junk = $urandom;
    @(negedge bus_clk);
    bus_req = 1'b1;
    bus_cmd = {w, ~w, a, (w ? d : junk)};
    @(negedge bus_clk);
    bus_req = 1'b0;
    chk(bus_busy == 1'b1, "R1 busy after accept", 64'(bus_busy), 64'd1);
    if (inject) begin
      bus_req = 1'b1;
      bus_cmd = {1'b1, 1'b0, ~a, ~d};
      @(negedge bus_clk);
      bus_req = 1'b0;
      chk(bus_busy == 1'b1, "R7 busy while outstanding", 64'(bus_busy), 64'd1);
    end
    n = 0;
    while (!bus_ack && n < 300) begin
      @(negedge bus_clk);
      n++;
    end
    chk(bus_ack == 1'b1, "R5 ack arrives", 64'(bus_ack), 64'd1);
    chk(bus_busy == 1'b0, "R7 busy low at ack", 64'(bus_busy), 64'd0);
    if (!w) chk(bus_rdata == rd_model(a), "R4 read data returned", 64'(bus_rdata), 64'(rd_model(a)));
    if (w) last_wdata = d;
    chk(wr_cnt == wc0 + int'(w), "R10 write count", 64'(wr_cnt), 64'(wc0 + int'(w)));
    chk(rd_cnt == rc0 + int'(!w), "R3 read count", 64'(rd_cnt), 64'(rc0 + int'(!w)));
    if (inject) begin
      repeat (30) @(negedge bus_clk);
      chk(ack_cnt == ac0 + 1 && wr_cnt == wc0 + int'(w), "R6 extra strobe ignored",
          64'(ack_cnt), 64'(ac0 + 1));
    end
  endtask

  task automatic hold_check(input int gap);
    logic [DW-1:0] saved;
    saved = bus_rdata;
    repeat (gap) @(negedge bus_clk);
    chk(bus_rdata == saved, "R5 rdata held", 64'(bus_rdata), 64'(saved));
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge sys_clk);
    sys_rst = 1'b0;
    repeat (4) @(negedge bus_clk);
    bus_rst = 1'b0;
    // R9 reset state
    chk(!bus_busy && !bus_ack && bus_rdata == '0, "R9 bus reset state",
        64'({bus_busy, bus_ack}), 64'd0);
    chk(!sys_wr_en && !sys_rd_en && sys_addr == '0 && sys_wdata == '0, "R9 sys reset state",
        64'({sys_wr_en, sys_rd_en}), 64'd0);

    // Directed corners
    txn(1'b0, '0, 32'h1234_5678, 1'b0);
    txn(1'b1, '1, 32'hFFFF_FFFF, 1'b0);
    hold_check(7);
    txn(1'b0, '1, 32'h0, 1'b0);
    hold_check(3);
    txn(1'b1, 22'h15_5555, 32'hA5A5_0F0F, 1'b1);
    txn(1'b0, 22'h15_5555, 32'hCAFE_F00D, 1'b1);
    txn(1'b1, 22'h00_0001, 32'h0000_0000, 1'b0);
    txn(1'b0, 22'h00_0001, 32'hFFFF_FFFF, 1'b0);

    // Constrained random mix
    for (int i = 0; i < 200; i++) begin
      bit w;
      w = $urandom_range(0, 1) == 1;
      txn(w, AW'($urandom), $urandom, $urandom_range(0, 9) == 0);
      hold_check($urandom_range(0, 5));
    end

    summary();
    $finish;
  end
endmodule